// File: doc/BRIEF.md
# Sub-Second Reload Divider with Deferred Load

This block divides an oscillator tick stream with a down-counter that reloads itself from a reload register each time it runs out. Each expiry produces a one-clock reload pulse, and that pulse serves as the sub-second time base. Software programs the reload value through a byte-wide register bus. The value is split over three byte locations, and the reload register is committed when the top byte is written. A committed value waits for the next natural expiry before the counter uses it.

Software also requests an oscillator-source code through a control location. The request normally becomes active at the next expiry. A force-load bit in the same control write reloads the counter at once and activates the written code at once. The block does not switch any clock itself. It only reports the active code.

The three counter bytes are read back through the same byte buffer that collects reload writes. A read of the low counter byte snapshots the whole counter into that buffer. This keeps the three read bytes coherent. It also means a counter read in the middle of a reload write sequence replaces the bytes already written.

Top module: `ssr_reload_timer`

## Requirements
- R1: After reset the counter holds the legalised reset reload value, `src_active` equals the reset source code, `reload_pulse` is 0, and a control read returns the reset source code in bits [SRC_W-1:0].
- R2: Each clock with `osc_tick` high and no force load decrements the counter by one. The counter holds its value when `osc_tick` is low.
- R3: A tick taken while the counter equals 1 reloads the counter from the committed reload register. `reload_pulse` is then high for exactly the one following clock, so the pulse period is the reload value in ticks.
- R4: Address 0 writes buffer bits 7:0 and address 1 writes bits 15:8. Address 2 writes bits 19:16 from data bits [3:0], ignores data bits [7:4], and commits the whole buffer to the reload register. The committed value does not reach the counter before the next expiry.
- R5: A committed reload value of 0 or 1 is stored as 2. The counter never holds 0.
- R6: A control write to address 3 stores data bits [1:0] as the requested source code. That code becomes active at the next expiry. A control read returns the active code in bits [1:0], with zeros above it.
- R7: A control write with data bit 7 set loads the counter from the committed reload register and activates the written source code. Both take effect on the next clock. No reload pulse is produced, and the force load wins over a tick in the same clock.
- R8: A read of address 0 returns counter bits 7:0 and copies the full counter into the shared buffer. Reads of addresses 1 and 2 return buffer bits 15:8 and bits 19:16 (zero-extended). A counter read between reload byte writes therefore replaces the bytes already written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe, one clock per access |
| bus_rd | input | 1 | Register read strobe, one clock per access |
| bus_addr | input | 2 | Register address: 0..2 counter/reload bytes, 3 control |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid while `bus_rd` is high, zero otherwise |
| osc_tick | input | 1 | One-clock tick from the selected oscillator |
| reload_pulse | output | 1 | One-clock pulse following each natural expiry |
| src_active | output | SRC_W | Currently active oscillator-source code |

## Verification
The bench uses the default 20-bit counter and 2-bit source code, but overrides the reset reload value to 5. With that setting the expiry at the reset value, and the pulse that follows it, arrive within a few ticks. Large reload values, including the full 20-bit maximum and values whose top data bits must be dropped, are reached through force loads and read back at once, with no need to count them down. Small forced reloads of 3 and 7 keep the deferred-load, deferred-source and tick-versus-force collision cases within a few dozen clocks.

// File: rtl/ssr_pkg.sv
package ssr_pkg;

  typedef enum logic [1:0] {
    REG_BYTE0 = 2'd0,
    REG_BYTE1 = 2'd1,
    REG_BYTE2 = 2'd2,
    REG_CTRL  = 2'd3
  } ssr_addr_e;

  localparam int BYTE_W        = 8;
  localparam int CTRL_LOAD_BIT = 7;

  // Select byte number idx out of a 32-bit word.
  function automatic logic [BYTE_W-1:0] byte_of(input logic [31:0] w, input int idx);
    return w[idx*BYTE_W +: BYTE_W];
  endfunction

endpackage

// File: rtl/ssr_bus_regs.sv
module ssr_bus_regs
  import ssr_pkg::*;
#(
  parameter int CNT_W = 20,
  parameter int SRC_W = 2,
  parameter logic [CNT_W-1:0] RST_LOAD = CNT_W'(32768),
  parameter logic [SRC_W-1:0] RST_SRC  = SRC_W'(2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [1:0]        bus_addr,
  input  logic [7:0]        bus_wdata,
  input  logic [CNT_W-1:0]  cnt_q,
  input  logic [SRC_W-1:0]  src_active,
  output logic [7:0]        bus_rdata,
  output logic [CNT_W-1:0]  reload_q,
  output logic [SRC_W-1:0]  src_req_q,
  output logic              force_evt,
  output logic [SRC_W-1:0]  force_src
);

  localparam int TOP_W = CNT_W - 16;
  localparam logic [CNT_W-1:0] MIN_RELOAD = CNT_W'(2);

  // Replace the illegal reload values 0 and 1 by the smallest legal one.
  function automatic logic [CNT_W-1:0] legalise(input logic [CNT_W-1:0] v);
    return (v < MIN_RELOAD) ? MIN_RELOAD : v;
  endfunction

  logic [CNT_W-1:0] buf_q;
  logic [CNT_W-1:0] commit_val;
  logic             wr_b0, wr_b1, wr_b2, wr_ctrl, rd_b0;

  assign wr_b0   = bus_wr && (bus_addr == REG_BYTE0);
  assign wr_b1   = bus_wr && (bus_addr == REG_BYTE1);
  assign wr_b2   = bus_wr && (bus_addr == REG_BYTE2);
  assign wr_ctrl = bus_wr && (bus_addr == REG_CTRL);
  assign rd_b0   = bus_rd && !bus_wr && (bus_addr == REG_BYTE0);

  assign commit_val = legalise({bus_wdata[TOP_W-1:0], buf_q[15:0]});
  assign force_evt  = wr_ctrl && bus_wdata[CTRL_LOAD_BIT];
  assign force_src  = bus_wdata[SRC_W-1:0];

  // Shared byte buffer: filled by writes, overwritten by a counter snapshot.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q <= '0;
    end else if (wr_b0) begin
      buf_q[7:0] <= bus_wdata;
    end else if (wr_b1) begin
      buf_q[15:8] <= bus_wdata;
    end else if (wr_b2) begin
      buf_q[CNT_W-1:16] <= bus_wdata[TOP_W-1:0];
    end else if (rd_b0) begin
      buf_q <= cnt_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload_q <= RST_LOAD;
    end else if (wr_b2) begin
      reload_q <= commit_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_req_q <= RST_SRC;
    end else if (wr_ctrl) begin
      src_req_q <= bus_wdata[SRC_W-1:0];
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      unique case (bus_addr)
        REG_BYTE0: bus_rdata = byte_of(32'(cnt_q), 0);
        REG_BYTE1: bus_rdata = byte_of(32'(buf_q), 1);
        REG_BYTE2: bus_rdata = byte_of(32'(buf_q), 2);
        default:   bus_rdata = byte_of(32'(src_active), 0);
      endcase
    end
  end

endmodule

// File: rtl/ssr_down_counter.sv
module ssr_down_counter #(
  parameter int CNT_W = 20,
  parameter logic [CNT_W-1:0] RST_LOAD = CNT_W'(32768)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             osc_tick,
  input  logic             force_evt,
  input  logic [CNT_W-1:0] reload_q,
  output logic [CNT_W-1:0] cnt_q,
  output logic             expire_evt,
  output logic             reload_pulse
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  // A force load takes precedence over an expiry in the same clock.
  assign expire_evt = osc_tick && (cnt_q == ONE) && !force_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= RST_LOAD;
    end else if (force_evt || expire_evt) begin
      cnt_q <= reload_q;
    end else if (osc_tick) begin
      cnt_q <= cnt_q - ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload_pulse <= 1'b0;
    end else begin
      reload_pulse <= expire_evt;
    end
  end

endmodule

// File: rtl/ssr_src_sel.sv
module ssr_src_sel #(
  parameter int SRC_W = 2,
  parameter logic [SRC_W-1:0] RST_SRC = SRC_W'(2)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             force_evt,
  input  logic [SRC_W-1:0] force_src,
  input  logic             expire_evt,
  input  logic [SRC_W-1:0] src_req_q,
  output logic [SRC_W-1:0] src_active
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_active <= RST_SRC;
    end else if (force_evt) begin
      src_active <= force_src;
    end else if (expire_evt) begin
      src_active <= src_req_q;
    end
  end

endmodule

// File: rtl/ssr_reload_timer.sv
module ssr_reload_timer #(
  parameter int CNT_W = 20,
  parameter int SRC_W = 2,
  parameter logic [CNT_W-1:0] RST_RELOAD = CNT_W'(32768),
  parameter logic [SRC_W-1:0] RST_SRC    = SRC_W'(2)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [1:0]       bus_addr,
  input  logic [7:0]       bus_wdata,
  output logic [7:0]       bus_rdata,
  input  logic             osc_tick,
  output logic             reload_pulse,
  output logic [SRC_W-1:0] src_active
);

  localparam logic [CNT_W-1:0] RST_LEGAL =
    (RST_RELOAD < CNT_W'(2)) ? CNT_W'(2) : RST_RELOAD;

  // The byte layout needs three bytes with a non-empty top byte,
  // and bit 7 of the control location is reserved for the force load.
  if (CNT_W < 17 || CNT_W > 24) begin : g_bad_cnt_w
    $error("CNT_W must lie in 17..24");
  end
  if (SRC_W < 1 || SRC_W > 7) begin : g_bad_src_w
    $error("SRC_W must lie in 1..7");
  end

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] reload_q;
  logic [SRC_W-1:0] src_req_q;
  logic [SRC_W-1:0] force_src;
  logic             force_evt;
  logic             expire_evt;

  ssr_bus_regs #(
    .CNT_W(CNT_W), .SRC_W(SRC_W), .RST_LOAD(RST_LEGAL), .RST_SRC(RST_SRC)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .cnt_q(cnt_q), .src_active(src_active),
    .bus_rdata(bus_rdata), .reload_q(reload_q), .src_req_q(src_req_q),
    .force_evt(force_evt), .force_src(force_src)
  );

  ssr_down_counter #(
    .CNT_W(CNT_W), .RST_LOAD(RST_LEGAL)
  ) u_cnt (
    .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .force_evt(force_evt),
    .reload_q(reload_q), .cnt_q(cnt_q), .expire_evt(expire_evt),
    .reload_pulse(reload_pulse)
  );

  ssr_src_sel #(
    .SRC_W(SRC_W), .RST_SRC(RST_SRC)
  ) u_src (
    .clk(clk), .rst_n(rst_n), .force_evt(force_evt), .force_src(force_src),
    .expire_evt(expire_evt), .src_req_q(src_req_q), .src_active(src_active)
  );

endmodule

// File: rtl/ssr_reload_timer_chk.sv
module ssr_reload_timer_chk #(
  parameter int CNT_W = 20,
  parameter int SRC_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             osc_tick,
  input logic             force_evt,
  input logic             expire_evt,
  input logic [CNT_W-1:0] cnt_q,
  input logic [CNT_W-1:0] reload_q,
  input logic             reload_pulse,
  input logic [SRC_W-1:0] src_active
);

  p_hold_no_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!osc_tick && !force_evt) |=> $stable(cnt_q));

  p_expire_reload_r3: assert property (@(posedge clk) disable iff (!rst_n)
    expire_evt |=> (reload_pulse && cnt_q == $past(reload_q)));

  p_pulse_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    reload_pulse |=> !reload_pulse);

  p_reload_legal_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (reload_q >= CNT_W'(2)) && (cnt_q != '0));

  p_src_deferred_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!expire_evt && !force_evt) |=> $stable(src_active));

  p_force_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    force_evt |=> (!reload_pulse && cnt_q == $past(reload_q)));

endmodule

bind ssr_reload_timer ssr_reload_timer_chk #(
  .CNT_W(CNT_W), .SRC_W(SRC_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .force_evt(force_evt),
  .expire_evt(expire_evt), .cnt_q(cnt_q), .reload_q(reload_q),
  .reload_pulse(reload_pulse), .src_active(src_active)
);

// File: tb/ssr_reload_timer_test.sv
module ssr_reload_timer_test;

  localparam int CNT_W = 20;
  localparam int SRC_W = 2;
  localparam logic [CNT_W-1:0] TB_RST_RELOAD = 20'd5;
  localparam logic [SRC_W-1:0] TB_RST_SRC    = 2'd2;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             bus_wr = 1'b0;
  logic             bus_rd = 1'b0;
  logic [1:0]       bus_addr = '0;
  logic [7:0]       bus_wdata = '0;
  logic [7:0]       bus_rdata;
  logic             osc_tick = 1'b0;
  logic             reload_pulse;
  logic [SRC_W-1:0] src_active;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  ssr_reload_timer #(
    .CNT_W(CNT_W), .SRC_W(SRC_W),
    .RST_RELOAD(TB_RST_RELOAD), .RST_SRC(TB_RST_SRC)
  ) uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .osc_tick(osc_tick), .reload_pulse(reload_pulse), .src_active(src_active)
  );

  typedef struct packed {
    logic [7:0]  b0;
    logic [7:0]  b1;
    logic [7:0]  b2;
    logic [19:0] expect_cnt;
  } vec_t;

  // Reload bytes written, then force-loaded; expected counter value.
  localparam vec_t VECS [6] = '{
    '{8'h06, 8'h00, 8'h00, 20'h00006},
    '{8'h00, 8'h00, 8'h00, 20'h00002},
    '{8'h01, 8'h00, 8'h00, 20'h00002},
    '{8'hFF, 8'hFF, 8'hFF, 20'hFFFFF},
    '{8'h45, 8'h23, 8'h01, 20'h12345},
    '{8'h00, 8'h01, 8'hF5, 20'h50100}
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic read_cnt(output logic [19:0] v);
    logic [7:0] lo, mid, hi;
    bus_read(2'd0, lo);
    bus_read(2'd1, mid);
    bus_read(2'd2, hi);
    v = {hi[3:0], mid, lo};
  endtask

  task automatic write_reload(input logic [19:0] v);
    bus_write(2'd0, v[7:0]);
    bus_write(2'd1, v[15:8]);
    bus_write(2'd2, {4'h0, v[19:16]});
  endtask

  // One tick; returns the pulse level in the clock after the tick edge.
  task automatic tick_one(output logic p);
    @(negedge clk);
    osc_tick = 1'b1;
    @(negedge clk);
    osc_tick = 1'b0;
    p = reload_pulse;
  endtask

  task automatic tick_n(input int n, output int pulses);
    logic p;
    pulses = 0;
    for (int i = 0; i < n; i++) begin
      tick_one(p);
      if (p) pulses++;
    end
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [19:0] cv;
    logic [7:0]  rd;
    logic        p;
    int          np;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    check(reload_pulse == 1'b0, "R1 pulse", 32'(reload_pulse), 32'd0);
    check(src_active == TB_RST_SRC, "R1 src", 32'(src_active), 32'(TB_RST_SRC));
    bus_read(2'd3, rd);
    check(rd == 8'(TB_RST_SRC), "R1 ctrl read", 32'(rd), 32'(TB_RST_SRC));
    read_cnt(cv);
    check(cv == TB_RST_RELOAD, "R1 counter", 32'(cv), 32'(TB_RST_RELOAD));

    // R2: decrement on tick, hold without tick
    tick_one(p);
    read_cnt(cv);
    check(cv == 20'd4, "R2 decrement", 32'(cv), 32'd4);
    repeat (4) @(negedge clk);
    read_cnt(cv);
    check(cv == 20'd4, "R2 hold", 32'(cv), 32'd4);

    // R3: three more ticks reach 1 without a pulse, the next one expires
    tick_n(3, np);
    check(np == 0, "R3 no early pulse", 32'(np), 32'd0);
    tick_one(p);
    check(p == 1'b1, "R3 pulse on expiry", 32'(p), 32'd1);
    @(negedge clk);
    check(reload_pulse == 1'b0, "R3 pulse one clock", 32'(reload_pulse), 32'd0);
    read_cnt(cv);
    check(cv == TB_RST_RELOAD, "R3 reload", 32'(cv), 32'(TB_RST_RELOAD));

    // R4/R5/R7: table of committed values applied by force load
    for (int i = 0; i < 6; i++) begin
      logic [1:0] s;
      s = 2'(i);
      bus_write(2'd0, VECS[i].b0);
      bus_write(2'd1, VECS[i].b1);
      bus_write(2'd2, VECS[i].b2);
      bus_write(2'd3, 8'h80 | 8'(s));
      check(reload_pulse == 1'b0, "R7 no pulse on force", 32'(reload_pulse), 32'd0);
      check(src_active == s, "R7 forced src", 32'(src_active), 32'(s));
      read_cnt(cv);
      check(cv == VECS[i].expect_cnt, "R4 R5 committed value", 32'(cv),
            32'(VECS[i].expect_cnt));
    end

    // R4: a committed value waits for the next expiry
    write_reload(20'd3);
    bus_write(2'd3, 8'h80);
    write_reload(20'd7);
    read_cnt(cv);
    check(cv == 20'd3, "R4 deferred", 32'(cv), 32'd3);
    tick_n(2, np);
    check(np == 0, "R4 no early pulse", 32'(np), 32'd0);
    tick_one(p);
    check(p == 1'b1, "R4 expiry pulse", 32'(p), 32'd1);
    read_cnt(cv);
    check(cv == 20'd7, "R4 new value after expiry", 32'(cv), 32'd7);

    // R6: requested source waits for the next expiry
    bus_write(2'd3, 8'h03);
    bus_read(2'd3, rd);
    check(rd == 8'h00, "R6 ctrl read before expiry", 32'(rd), 32'd0);
    tick_n(6, np);
    check(src_active == 2'd0, "R6 src before expiry", 32'(src_active), 32'd0);
    tick_one(p);
    check(src_active == 2'd3, "R6 src after expiry", 32'(src_active), 32'd3);
    bus_read(2'd3, rd);
    check(rd == 8'h03, "R6 ctrl read after expiry", 32'(rd), 32'd3);

    // R7: force load in the same clock as an expiring tick
    tick_n(6, np);
    @(negedge clk);
    osc_tick = 1'b1; bus_wr = 1'b1; bus_addr = 2'd3; bus_wdata = 8'h81;
    @(negedge clk);
    osc_tick = 1'b0; bus_wr = 1'b0;
    check(reload_pulse == 1'b0, "R7 force beats tick", 32'(reload_pulse), 32'd0);
    check(src_active == 2'd1, "R7 src on collision", 32'(src_active), 32'd1);
    read_cnt(cv);
    check(cv == 20'd7, "R7 counter on collision", 32'(cv), 32'd7);

    // R8: counter read between byte writes replaces the buffered bytes
    tick_one(p);
    bus_write(2'd0, 8'h22);
    bus_write(2'd1, 8'h11);
    bus_read(2'd0, rd);
    check(rd == 8'h06, "R8 low byte read", 32'(rd), 32'd6);
    bus_read(2'd1, rd);
    check(rd == 8'h00, "R8 buffer mid byte", 32'(rd), 32'd0);
    bus_read(2'd2, rd);
    check(rd == 8'h00, "R8 buffer top byte", 32'(rd), 32'd0);
    bus_write(2'd2, 8'h03);
    bus_write(2'd3, 8'h80);
    read_cnt(cv);
    check(cv == 20'h30006, "R8 corrupted commit", 32'(cv), 32'h30006);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule